// File: doc/BRIEF.md
# 32-Line GPIO Bank with Split Direction Control

This block is one bank of 32 general-purpose I/O lines. Software reaches it through a small memory-mapped register port: a write strobe, a byte address, 32-bit write data and combinational read data. Each bank is a separate instance with its own registers. On the pad side, every line has an output value, an output enable and an input value.

Each line has a 2-bit direction code. Because the codes take 64 bits in all, they are split over two 32-bit control registers. The low-half register covers lines 0 to 15 and the high-half register covers lines 16 to 31. The two registers are not adjacent in the address map. A code of 1 selects output. A code of 0 selects input, and codes 2 and 3 are reserved and also behave as input.

A line drives its pad only when its direction code is 1 and its bit in a separate output-enable register is also set. Output levels are written through a 32-bit data register. Reading the same register returns the output latch for driven lines and the synchronised pad level for every other line.

Top module: `gpio_bank`

## Requirements
- R1: After a cycle with `rstN` low, padOe and padOut are all zero and every mapped register reads back zero.
- R2: Offset 0x04 holds the direction codes of lines 0–15 and offset 0x0C holds those of lines 16–31. Line i uses bits [2k+1:2k] of its register, with k = i mod 16. Both registers read back exactly what was written, reserved codes included.
- R3: Offset 0x08 is the output-enable register, one bit per line (bit i is line i), and it reads back as written.
- R4: padOe[i] is 1 exactly when line i has direction code 1 and output-enable bit i is set. Codes 0, 2 and 3 never drive, whatever the enable bit holds.
- R5: padOut[i] equals bit i of the output latch while line i is driven, and is 0 otherwise. A write to offset 0x00 loads the whole latch.
- R6: A write changes state on the rising clock edge where `wrEn` is high. With `wrEn` low, no register, padOe or padOut changes.
- R7: A pad level applied before clock edge k appears in the data-register readback after edge k+1 (two synchroniser flops) and not after edge k alone.
- R8: A read of offset 0x00 returns the latch bit for driven lines and the synchronised pad bit for undriven lines. Pad levels on driven lines do not appear.
- R9: A read of any offset other than 0x00, 0x04, 0x08 or 0x0C returns zero, and a write to such an offset changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset of the register being accessed |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| padOut | output | 32 | Level driven onto each pad |
| padOe | output | 32 | Per-pad drive enable |
| padIn | input | 32 | Level seen on each pad, asynchronous |

## Verification
The assertions assume three things about the inputs:
- `wrEn`, `addr` and `wrData` are settled at each rising edge.
- `addr` holds a meaningful offset whenever `wrEn` is high.
- Pad levels can change at any time, since they pass through the synchroniser.

The bench keeps within these assumptions by changing every input only on falling edges. It checks each write's effect on the pads half a cycle after the edge that captured it. It changes pad levels only on lines that are not being driven, except for one case that shows driven lines ignore their pad.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int OFF_DATA  = 'h00;
  localparam int OFF_DIRLO = 'h04;
  localparam int OFF_OE    = 'h08;
  localparam int OFF_DIRHI = 'h0C;

  localparam logic [1:0] DIR_IN  = 2'd0;
  localparam logic [1:0] DIR_OUT = 2'd1;

  typedef struct packed {
    logic loadData;
    logic loadDirLo;
    logic loadOe;
    logic loadDirHi;
  } gpioStrobe_t;

  typedef enum logic [2:0] {
    SEL_DATA,
    SEL_DIRLO,
    SEL_OE,
    SEL_DIRHI,
    SEL_NONE
  } gpioSel_e;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output gpioStrobe_t       stb,
  output gpioSel_e          rdSel
);

  always_comb begin
    rdSel = SEL_NONE;
    if (addr == ADDR_W'(OFF_DATA))       rdSel = SEL_DATA;
    else if (addr == ADDR_W'(OFF_DIRLO)) rdSel = SEL_DIRLO;
    else if (addr == ADDR_W'(OFF_OE))    rdSel = SEL_OE;
    else if (addr == ADDR_W'(OFF_DIRHI)) rdSel = SEL_DIRHI;
  end

  always_comb begin
    stb           = '0;
    stb.loadData  = wrEn && (rdSel == SEL_DATA);
    stb.loadDirLo = wrEn && (rdSel == SEL_DIRLO);
    stb.loadOe    = wrEn && (rdSel == SEL_OE);
    stb.loadDirHi = wrEn && (rdSel == SEL_DIRHI);
  end

  always_comb begin
    assert ($countones(stb) <= 1)
      else $error("more than one register strobe active"); // R9
  end

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int LINES       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  gpioStrobe_t      stb,
  input  gpioSel_e         rdSel,
  input  logic [LINES-1:0] wrData,
  input  logic [LINES-1:0] padIn,
  output logic [LINES-1:0] rdData,
  output logic [LINES-1:0] padOut,
  output logic [LINES-1:0] padOe
);

  localparam int HALF = LINES / 2;

  logic [LINES-1:0] outLatch;
  logic [LINES-1:0] oeReg;
  logic [LINES-1:0] dirLo;
  logic [LINES-1:0] dirHi;
  logic [LINES-1:0] syncQ [SYNC_STAGES];
  logic [LINES-1:0] driveMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLatch <= '0;
      oeReg    <= '0;
      dirLo    <= '0;
      dirHi    <= '0;
    end else begin
      if (stb.loadData)  outLatch <= wrData;
      if (stb.loadOe)    oeReg    <= wrData;
      if (stb.loadDirLo) dirLo    <= wrData;
      if (stb.loadDirHi) dirHi    <= wrData;
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncQ[s] <= '0;
      end else if (s == 0) begin
        syncQ[s] <= padIn;
      end else begin
        syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [1:0] dirCode;
    if (i < HALF) begin : g_lo
      assign dirCode = dirLo[2*i +: 2];
    end else begin : g_hi
      assign dirCode = dirHi[2*(i-HALF) +: 2];
    end
    assign driveMask[i] = (dirCode == DIR_OUT) && oeReg[i];
  end

  assign padOe  = driveMask;
  assign padOut = outLatch & driveMask;

  always_comb begin
    unique case (rdSel)
      SEL_DATA:  rdData = (outLatch & driveMask) | (syncQ[SYNC_STAGES-1] & ~driveMask);
      SEL_DIRLO: rdData = dirLo;
      SEL_OE:    rdData = oeReg;
      SEL_DIRHI: rdData = dirHi;
      default:   rdData = '0;
    endcase
  end

  AST_OE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadOe |=> oeReg == $past(wrData)) else $error("oe write lost"); // R3

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.loadDirLo || stb.loadDirHi) |=> $stable(dirLo) && $stable(dirHi))
    else $error("direction changed without strobe"); // R6

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int LINES       = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LINES-1:0]  wrData,
  output logic [LINES-1:0]  rdData,
  output logic [LINES-1:0]  padOut,
  output logic [LINES-1:0]  padOe,
  input  logic [LINES-1:0]  padIn
);

  localparam int HALF = LINES / 2;

  gpioStrobe_t stb;
  gpioSel_e    rdSel;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn  (wrEn),
    .addr  (addr),
    .stb   (stb),
    .rdSel (rdSel)
  );

  gpio_bank_dp #(.LINES(LINES), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .rdSel  (rdSel),
    .wrData (wrData),
    .padIn  (padIn),
    .rdData (rdData),
    .padOut (padOut),
    .padOe  (padOe)
  );

  AST_STABLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(padOe) && $stable(padOut)) else $error("pads moved without write"); // R6

  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFF_OE)) |=> (padOe & ~$past(wrData)) == '0)
    else $error("pad driven without enable"); // R4

  AST_UNDRIVEN_OUT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (padOut & ~padOe) == '0) else $error("undriven pad shows level"); // R5

  always_comb begin
    if (addr != ADDR_W'(OFF_DATA) && addr != ADDR_W'(OFF_DIRLO) &&
        addr != ADDR_W'(OFF_OE) && addr != ADDR_W'(OFF_DIRHI)) begin
      AST_UNMAPPED_ZERO: assert (rdData == '0) else $error("unmapped read nonzero"); // R9
    end
  end

  for (genvar i = 0; i < HALF; i++) begin : g_rsv
    AST_NONOUT_CODE_LO: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == ADDR_W'(OFF_DIRLO) && wrData[2*i +: 2] != DIR_OUT) |=> !padOe[i])
      else $error("non-output code drives low line"); // R4
    AST_NONOUT_CODE_HI: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == ADDR_W'(OFF_DIRHI) && wrData[2*i +: 2] != DIR_OUT) |=> !padOe[i+HALF])
      else $error("non-output code drives high line"); // R4
  end

endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, padOut, padOe;
  logic [31:0] padIn = '0;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  gpio_bank u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .padOut(padOut), .padOe(padOe), .padIn(padIn)
  );

  localparam int NV = 12;
  localparam logic [4:0]  VA  [NV] = '{5'h08, 5'h00, 5'h04, 5'h0C, 5'h04, 5'h08,
                                       5'h10, 5'h14, 5'h00, 5'h0C, 5'h08, 5'h00};
  localparam logic [31:0] VD  [NV] = '{32'hFFFFFFFF, 32'hA5A55A5A, 32'h55555555, 32'h00000001,
                                       32'hE4E4E4E4, 32'h00000F0F, 32'hFFFFFFFF, 32'hFFFFFFFF,
                                       32'h00000000, 32'h55555555, 32'hFFFF0000, 32'h12345678};
  localparam logic [31:0] VOE [NV] = '{32'h0, 32'h0, 32'h0000FFFF, 32'h0001FFFF,
                                       32'h00012222, 32'h00000202, 32'h00000202, 32'h00000202,
                                       32'h00000202, 32'h00000202, 32'hFFFF0000, 32'hFFFF0000};
  localparam logic [31:0] VPO [NV] = '{32'h0, 32'h0, 32'h00005A5A, 32'h00015A5A,
                                       32'h00010202, 32'h00000202, 32'h00000202, 32'h00000202,
                                       32'h0, 32'h0, 32'h0, 32'h12340000};
  localparam logic [31:0] VRD [NV] = '{32'hFFFFFFFF, 32'h0, 32'h55555555, 32'h00000001,
                                       32'hE4E4E4E4, 32'h00000F0F, 32'h0, 32'h0,
                                       32'h0, 32'h55555555, 32'hFFFF0000, 32'h12340000};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 padOe", padOe, 32'h0);
    check("R1 padOut", padOut, 32'h0);
    rd(5'h00, r); check("R1 data", r, 32'h0);
    rd(5'h04, r); check("R1 dirLo", r, 32'h0);
    rd(5'h08, r); check("R1 oe", r, 32'h0);
    rd(5'h0C, r); check("R1 dirHi", r, 32'h0);

    // vector table: R2 R3 R4 R5 R9
    for (int v = 0; v < NV; v++) begin
      wr(VA[v], VD[v]);
      check($sformatf("R4 padOe v%0d", v), padOe, VOE[v]);
      check($sformatf("R5 padOut v%0d", v), padOut, VPO[v]);
      rd(VA[v], r);
      check($sformatf("R2/R3/R9 readback v%0d", v), r, VRD[v]);
    end

    // R6: strobe low, no effect
    @(negedge clk);
    wrEn = 1'b0; addr = 5'h08; wrData = 32'h0;
    @(negedge clk);
    check("R6 padOe held", padOe, 32'hFFFF0000);
    addr = 5'h00; wrData = 32'hFFFFFFFF;
    @(negedge clk);
    check("R6 padOut held", padOut, 32'h12340000);

    // R7/R8: synchroniser latency and read mux
    padIn = 32'hFFFFABCD;
    @(negedge clk);
    rd(5'h00, r); check("R7 one edge not yet", r, 32'h12340000);
    @(negedge clk);
    rd(5'h00, r); check("R7 two edges visible", r, 32'h1234ABCD);
    check("R8 driven pads ignore pins", r[31:16], 16'h1234);
    padIn = 32'h0;
    repeat (2) @(negedge clk);
    rd(5'h00, r); check("R8 pins cleared", r, 32'h12340000);

    // R9: unmapped write after full setup changes nothing
    wr(5'h1C, 32'h0);
    check("R9 padOe", padOe, 32'hFFFF0000);
    rd(5'h08, r); check("R9 oe intact", r, 32'hFFFF0000);

    // R1: reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check("R1 padOe after reset", padOe, 32'h0);
    check("R1 padOut after reset", padOut, 32'h0);
    rd(5'h0C, r); check("R1 dirHi after reset", r, 32'h0);
    rd(5'h08, r); check("R1 oe after reset", r, 32'h0);

    finish_run();
  end

endmodule